// File: doc/BRIEF.md
# Accumulator Processor with Device Input/Output

This block is a small processor built around one accumulator. A multicycle control state machine steps through fetch, decode and execute for every instruction and holds a program counter, an instruction register, the accumulator and five result flags. It drives one word-wide memory port (address, read strobe, write strobe, write data, read data) and one device port (device number, input strobe, output strobe, write data, read data). The machine is meant to run short programs that take values from devices, work on them in memory and report a result on another device.

An instruction word holds a 7-bit opcode in bits 31:25 and a 25-bit operand in bits 24:0. The operand is a memory address for memory instructions, a device number for the two device instructions, and a target address for the two branch instructions. A read strobe on either port is answered on the read-data input in the following cycle. After a Halt the machine stops fetching and raises `halted` until the next reset, so the final memory image can be inspected.

Top module: `acc_cpu`

## Requirements
- R1: An active-low asynchronous `rst_n` clears the program counter, accumulator, instruction register and flags. While reset is held, the machine sits in the fetch state: `mem_rd` is high with `mem_addr` 0, every other strobe is low, `halted` is low and `flags` is 0.
- R2: A fetch raises `mem_rd` for one cycle with `mem_addr` equal to the program counter. The word on `mem_rdata` in the next cycle becomes the instruction and the counter advances by one. Instructions without a data read take 3 cycles. Input, Load, Add and Subt take 4 cycles.
- R3: Input (opcode 7'b1000100) raises `io_in_stb` for one cycle with `io_dev` equal to the operand. The word on `io_rdata` in the next cycle is written to the accumulator.
- R4: Store (opcode 7'b1000111) raises `mem_wr` for exactly one cycle with `mem_addr` equal to the operand and `mem_wdata` equal to the accumulator.
- R5: Load (7'h01), Add (7'h02) and Subt (7'h03) read memory at the operand. Load copies the word into the accumulator. Add and Subt write accumulator plus word, or accumulator minus word, modulo 2^32.
- R6: Add and Subt update `flags`. The bit positions are: bit 4 negative (the result's top bit), bit 3 positive (neither negative nor zero), bit 2 zero, bit 1 carry and bit 0 overflow. Carry is the carry-out for Add and no-borrow for Subt. Overflow is signed two's-complement overflow.
- R7: Every instruction other than Add and Subt leaves `flags` unchanged.
- R8: Jge (7'h04) loads the operand into the program counter when the positive or the zero flag is set. Otherwise execution continues with the next sequential instruction.
- R9: Jump (7'h05) loads the operand into the program counter unconditionally.
- R10: Output (7'h06) raises `io_out_stb` for one cycle with `io_dev` equal to the operand and `io_wdata` equal to the accumulator.
- R11: Halt (7'h7F) raises `halted` in the cycle after its execute step. `halted` then stays high and no strobe is asserted until reset.
- R12: Any other opcode is a no-operation. It takes 3 cycles, raises no strobe beyond its own fetch, and leaves the accumulator and flags unchanged.
- R13: At most one of `mem_rd`, `mem_wr`, `io_in_stb` and `io_out_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 25 | Memory address (program counter or operand) |
| mem_rd | output | 1 | Memory read strobe; data expected next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data (accumulator) |
| mem_rdata | input | 32 | Memory read data |
| io_dev | output | 25 | Device number (operand) |
| io_in_stb | output | 1 | Device input strobe; data expected next cycle |
| io_out_stb | output | 1 | Device output strobe |
| io_wdata | output | 32 | Device output data (accumulator) |
| io_rdata | input | 32 | Device input data |
| flags | output | 5 | Result flags {neg, pos, zero, carry, ovf} |
| halted | output | 1 | High while in the halt state |

## Verification
The assertions assume that memory and the device answer a read strobe with stable data in the following cycle and leave the read-data inputs unchanged while the machine does not consume them. The stimulus respects this by updating `mem_rdata` and `io_rdata` only in the cycle of a matching strobe, away from the clock edge. The assertions also assume that programs keep the program counter well below the operand range, so the increment never wraps. The bench places its programs in the first 64 words and its variables above them. The signed and unsigned edge operands (0, ±1, ±100, the most positive value and the most negative value) sweep every pair, which drives both branch directions, carry, and overflow in both signs.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 7;

  localparam logic [OPC_W-1:0] OP_INPUT  = 7'b1000100;
  localparam logic [OPC_W-1:0] OP_STORE  = 7'b1000111;
  localparam logic [OPC_W-1:0] OP_LOAD   = 7'h01;
  localparam logic [OPC_W-1:0] OP_ADD    = 7'h02;
  localparam logic [OPC_W-1:0] OP_SUB    = 7'h03;
  localparam logic [OPC_W-1:0] OP_JGE    = 7'h04;
  localparam logic [OPC_W-1:0] OP_JUMP   = 7'h05;
  localparam logic [OPC_W-1:0] OP_OUTPUT = 7'h06;
  localparam logic [OPC_W-1:0] OP_HALT   = 7'h7F;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_MEMRD,
    ST_IORD,
    ST_HALT
  } cpu_state_e;

  typedef enum logic [1:0] {
    ACC_FROM_ALU,
    ACC_FROM_MEM,
    ACC_FROM_IO
  } acc_src_e;

  // bit 4 .. bit 0
  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic carry;
    logic ovf;
  } cpu_flags_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              sub,
  output logic [DATA_W-1:0] result,
  output cpu_flags_t        res_flags
);

  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_carry(input logic [DATA_W-1:0] x,
                                                input logic [DATA_W-1:0] y,
                                                input logic cin);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, cin};
  endfunction

  function automatic logic signed_ovf(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y,
                                      input logic [DATA_W-1:0] r);
    return (x[MSB] == y[MSB]) && (r[MSB] != x[MSB]);
  endfunction

  logic [DATA_W-1:0] opb_eff;
  logic [DATA_W:0]   wide_sum;

  always_comb begin
    opb_eff         = sub ? ~opb : opb;
    wide_sum        = add_carry(opa, opb_eff, sub);
    result          = wide_sum[DATA_W-1:0];
    res_flags.neg   = result[MSB];
    res_flags.zero  = (result == '0);
    res_flags.pos   = !result[MSB] && (result != '0);
    res_flags.carry = wide_sum[DATA_W];
    res_flags.ovf   = signed_ovf(opa, opb_eff, result);
  end

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
  import acc_cpu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_pos,
  input  logic             flag_zero,
  output logic             take_branch
);

  logic is_jump;
  logic is_jge;

  always_comb begin
    is_jump     = (opcode == OP_JUMP);
    is_jge      = (opcode == OP_JGE);
    take_branch = is_jump || (is_jge && (flag_pos || flag_zero));
  end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             addr_from_pc,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             io_in_stb,
  output logic             io_out_stb,
  output logic             decode_en,
  output logic             exec_en,
  output logic             acc_we,
  output acc_src_e         acc_src,
  output logic             alu_sub,
  output logic             flags_we,
  output logic             halted
);

  cpu_state_e state_q;
  cpu_state_e state_d;

  logic is_load, is_add, is_sub, is_store, is_in, is_out, is_halt;
  logic needs_mem;

  always_comb begin
    is_load   = (opcode == OP_LOAD);
    is_add    = (opcode == OP_ADD);
    is_sub    = (opcode == OP_SUB);
    is_store  = (opcode == OP_STORE);
    is_in     = (opcode == OP_INPUT);
    is_out    = (opcode == OP_OUTPUT);
    is_halt   = (opcode == OP_HALT);
    needs_mem = is_load || is_add || is_sub;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: state_d = ST_EXEC;
      ST_EXEC: begin
        if (is_halt)        state_d = ST_HALT;
        else if (needs_mem) state_d = ST_MEMRD;
        else if (is_in)     state_d = ST_IORD;
        else                state_d = ST_FETCH;
      end
      ST_MEMRD:  state_d = ST_FETCH;
      ST_IORD:   state_d = ST_FETCH;
      ST_HALT:   state_d = ST_HALT;
      default:   state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  always_comb begin
    addr_from_pc = (state_q == ST_FETCH);
    exec_en      = (state_q == ST_EXEC);
    decode_en    = (state_q == ST_DECODE);
    mem_rd       = (state_q == ST_FETCH) || (exec_en && needs_mem);
    mem_wr       = exec_en && is_store;
    io_in_stb    = exec_en && is_in;
    io_out_stb   = exec_en && is_out;
    acc_we       = (state_q == ST_MEMRD) || (state_q == ST_IORD);
    if (state_q == ST_IORD) acc_src = ACC_FROM_IO;
    else if (is_load)       acc_src = ACC_FROM_MEM;
    else                    acc_src = ACC_FROM_ALU;
    alu_sub      = is_sub;
    flags_we     = (state_q == ST_MEMRD) && (is_add || is_sub);
    halted       = (state_q == ST_HALT);
  end

  // R13: strobes never overlap
  a_r13_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_in_stb, io_out_stb}));

  // R4: a store write lasts a single cycle
  a_r4_store_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> !mem_wr);

  // R3: device input strobe is followed by an accumulator write
  a_r3_input_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    io_in_stb |=> (acc_we && !io_in_stb));

  // R11: halt is sticky
  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R11: nothing is strobed while halted
  a_r11_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !(mem_rd || mem_wr || io_in_stb || io_out_stb));

  // R2: every fetch read is followed by a decode step
  a_r2_fetch_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && addr_from_pc) |=> decode_en);

endmodule

// File: rtl/acc_cpu_regs.sv
module acc_cpu_regs
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int OPD_W  = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decode_en,
  input  logic              exec_en,
  input  logic              take_branch,
  input  logic              acc_we,
  input  acc_src_e          acc_src,
  input  logic              flags_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] alu_result,
  input  cpu_flags_t        alu_flags,
  output logic [OPD_W-1:0]  pc,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] acc,
  output cpu_flags_t        flags
);

  logic [OPD_W-1:0] operand;
  assign operand = ir[OPD_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
      ir <= '0;
    end else if (decode_en) begin
      ir <= mem_rdata;
      pc <= pc + OPD_W'(1);
    end else if (exec_en && take_branch) begin
      pc <= operand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (acc_we) begin
      case (acc_src)
        ACC_FROM_MEM: acc <= mem_rdata;
        ACC_FROM_IO:  acc <= io_rdata;
        default:      acc <= alu_result;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags <= '0;
    else if (flags_we) flags <= alu_flags;
  end

  // R2: decode advances the program counter by one
  a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    decode_en |=> (pc == $past(pc) + OPD_W'(1)));

  // R8 / R9: a resolved branch lands on the operand
  a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && take_branch) |=> (pc == $past(operand)));

  // R8: an untaken step in execute keeps the program counter
  a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !take_branch) |=> $stable(pc));

  // R7: flags only move on an arithmetic write-back
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_we |=> $stable(flags));

  // R6: exactly one of negative, positive, zero after arithmetic
  a_r6_sign_class: assert property (@(posedge clk) disable iff (!rst_n)
    flags_we |=> $onehot({flags.neg, flags.pos, flags.zero}));

  // R12: the accumulator holds unless written
  a_r12_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_we |=> $stable(acc));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter  int DATA_W = 32,
  localparam int OPD_W  = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [OPD_W-1:0]  mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [OPD_W-1:0]  io_dev,
  output logic              io_in_stb,
  output logic              io_out_stb,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [4:0]        flags,
  output logic              halted
);

  logic              addr_from_pc;
  logic              decode_en;
  logic              exec_en;
  logic              acc_we;
  acc_src_e          acc_src;
  logic              alu_sub;
  logic              flags_we;
  logic              take_branch;
  logic [OPD_W-1:0]  pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] acc;
  cpu_flags_t        flags_q;
  logic [DATA_W-1:0] alu_result;
  cpu_flags_t        alu_flags;
  logic [OPC_W-1:0]  opcode;
  logic [OPD_W-1:0]  operand;

  assign opcode  = ir[DATA_W-1 -: OPC_W];
  assign operand = ir[OPD_W-1:0];

  acc_cpu_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (opcode),
    .addr_from_pc (addr_from_pc),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .io_in_stb    (io_in_stb),
    .io_out_stb   (io_out_stb),
    .decode_en    (decode_en),
    .exec_en      (exec_en),
    .acc_we       (acc_we),
    .acc_src      (acc_src),
    .alu_sub      (alu_sub),
    .flags_we     (flags_we),
    .halted       (halted)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .opa       (acc),
    .opb       (mem_rdata),
    .sub       (alu_sub),
    .result    (alu_result),
    .res_flags (alu_flags)
  );

  acc_cpu_branch u_branch (
    .opcode      (opcode),
    .flag_pos    (flags_q.pos),
    .flag_zero   (flags_q.zero),
    .take_branch (take_branch)
  );

  acc_cpu_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .decode_en   (decode_en),
    .exec_en     (exec_en),
    .take_branch (take_branch),
    .acc_we      (acc_we),
    .acc_src     (acc_src),
    .flags_we    (flags_we),
    .mem_rdata   (mem_rdata),
    .io_rdata    (io_rdata),
    .alu_result  (alu_result),
    .alu_flags   (alu_flags),
    .pc          (pc),
    .ir          (ir),
    .acc         (acc),
    .flags       (flags_q)
  );

  assign mem_addr  = addr_from_pc ? pc : operand;
  assign mem_wdata = acc;
  assign io_dev    = operand;
  assign io_wdata  = acc;
  assign flags     = flags_q;

endmodule

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int OPD_W      = 25;

  localparam logic [6:0] T_IN   = 7'b1000100;
  localparam logic [6:0] T_ST   = 7'b1000111;
  localparam logic [6:0] T_LD   = 7'h01;
  localparam logic [6:0] T_ADD  = 7'h02;
  localparam logic [6:0] T_SUB  = 7'h03;
  localparam logic [6:0] T_JGE  = 7'h04;
  localparam logic [6:0] T_JMP  = 7'h05;
  localparam logic [6:0] T_OUT  = 7'h06;
  localparam logic [6:0] T_HLT  = 7'h7F;
  localparam logic [6:0] T_NOP  = 7'h55;

  logic              clk;
  logic              rst_n;
  logic [OPD_W-1:0]  mem_addr;
  logic              mem_rd, mem_wr;
  logic [DATA_W-1:0] mem_wdata, mem_rdata;
  logic [OPD_W-1:0]  io_dev;
  logic              io_in_stb, io_out_stb;
  logic [DATA_W-1:0] io_wdata, io_rdata;
  logic [4:0]        flags;
  logic              halted;

  acc_cpu #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_dev(io_dev), .io_in_stb(io_in_stb), .io_out_stb(io_out_stb),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .flags(flags), .halted(halted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] mem [0:63];
  logic [31:0] in_q [0:3];
  int          in_ptr;
  int          out_cnt;
  logic [24:0] out_dev;
  logic [31:0] out_val;
  int          halt_strobes;
  int          exp_in_dev;
  bit          in_dev_bad;
  bit          multi_strobe;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] op, input int unsigned opd);
    logic [31:0] w;
    w = opd;
    return {op, w[24:0]};
  endfunction

  // flags {neg,pos,zero,carry,ovf} recomputed with wide signed arithmetic
  function automatic logic [4:0] ref_flags(input logic [31:0] a, input logic [31:0] b,
                                           input bit sub);
    longint sa, sb, s;
    logic [31:0] r;
    logic n, z, p, c, v;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    s  = sub ? (sa - sb) : (sa + sb);
    r  = s[31:0];
    n  = r[31];
    z  = (r == 32'd0);
    p  = !n && !z;
    if (sub) c = (a >= b);
    else     c = ((64'(a) + 64'(b)) >> 32) != 0;
    v  = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    return {n, p, z, c, v};
  endfunction

  task automatic clear_mem();
    for (int k = 0; k < 64; k++) mem[k] = 32'd0;
  endtask

  task automatic reset_and_check();
    rst_n     = 1'b0;
    mem_rdata = '0;
    io_rdata  = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(mem_rd == 1'b1 && mem_addr == '0, "R1 fetch at zero", {7'd0, mem_addr}, 32'd0);
    chk(!mem_wr && !io_in_stb && !io_out_stb && !halted, "R1 quiet",
        {28'd0, mem_wr, io_in_stb, io_out_stb, halted}, 32'd0);
    chk(flags == 5'd0, "R1 flags", {27'd0, flags}, 32'd0);
  endtask

  task automatic service();
    if ($countones({mem_rd, mem_wr, io_in_stb, io_out_stb}) > 1) multi_strobe = 1'b1;
    if (mem_rd) mem_rdata = mem[mem_addr[5:0]];
    if (mem_wr) mem[mem_addr[5:0]] = mem_wdata;
    if (io_in_stb) begin
      if (int'(io_dev) != exp_in_dev) in_dev_bad = 1'b1;
      io_rdata = in_q[in_ptr];
      in_ptr++;
    end
    if (io_out_stb) begin
      out_dev = io_dev;
      out_val = io_wdata;
      out_cnt++;
    end
  endtask

  task automatic run(output int cycles);
    in_ptr = 0; out_cnt = 0; halt_strobes = 0;
    in_dev_bad = 1'b0; multi_strobe = 1'b0;
    out_dev = '0; out_val = '0;
    rst_n = 1'b1;
    cycles = 0;
    while (!halted && cycles < 400) begin
      service();
      @(posedge clk);
      cycles++;
      @(negedge clk);
    end
    repeat (10) begin
      if (mem_rd || mem_wr || io_in_stb || io_out_stb || !halted) halt_strobes++;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic load_compute_prog();
    clear_mem();
    mem[0]  = enc(T_IN, 33);
    mem[1]  = enc(T_ST, 40);
    mem[2]  = enc(T_IN, 33);
    mem[3]  = enc(T_ST, 41);
    mem[4]  = enc(T_LD, 40);
    mem[5]  = enc(T_SUB, 41);
    mem[6]  = enc(T_JGE, 11);
    mem[7]  = enc(T_LD, 40);
    mem[8]  = enc(T_ADD, 41);
    mem[9]  = enc(T_ST, 42);
    mem[10] = enc(T_JMP, 14);
    mem[11] = enc(T_LD, 40);
    mem[12] = enc(T_SUB, 41);
    mem[13] = enc(T_ST, 42);
    mem[14] = enc(T_LD, 42);
    mem[15] = enc(T_OUT, 2049);
    mem[16] = enc(T_HLT, 0);
  endtask

  logic [31:0] vals [0:7];

  initial begin
    int cyc;
    logic [31:0] a, b, diff, exp_c;
    logic [4:0]  exp_f;
    int          exp_cyc;

    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h0000_0064; vals[3] = 32'hFFFF_FFFF;
    vals[4] = 32'h7FFF_FFFF; vals[5] = 32'h8000_0000;
    vals[6] = 32'hFFFF_FF9C; vals[7] = 32'h0000_0002;

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        a = vals[i];
        b = vals[j];
        reset_and_check();
        load_compute_prog();
        in_q[0] = a; in_q[1] = b; in_q[2] = 32'd0; in_q[3] = 32'd0;
        exp_in_dev = 33;
        run(cyc);
        diff = a - b;
        if (diff[31] == 1'b0) begin
          exp_c   = diff;
          exp_f   = ref_flags(a, b, 1'b1);
          exp_cyc = 46;
        end else begin
          exp_c   = a + b;
          exp_f   = ref_flags(a, b, 1'b0);
          exp_cyc = 49;
        end
        chk(mem[42] == exp_c, "R4 R5 R8 stored result", mem[42], exp_c);
        chk(mem[40] == a && mem[41] == b, "R3 R4 inputs stored", mem[41], b);
        chk(out_cnt == 1 && out_val == exp_c, "R10 output value", out_val, exp_c);
        chk(out_dev == 25'd2049, "R10 output device", {7'd0, out_dev}, 32'd2049);
        chk(flags == exp_f, "R6 R7 final flags", {27'd0, flags}, {27'd0, exp_f});
        chk(cyc == exp_cyc, "R2 R8 cycle count", cyc, exp_cyc);
        chk(!in_dev_bad && in_ptr == 2, "R3 input device", in_ptr, 2);
        chk(halt_strobes == 0, "R11 halted quiet", halt_strobes, 0);
        chk(!multi_strobe, "R13 single strobe", {31'd0, multi_strobe}, 32'd0);
      end
    end

    // undefined opcode, jump over a store, output, jump to halt
    reset_and_check();
    clear_mem();
    mem[0]  = enc(T_IN, 3);
    mem[1]  = enc(T_NOP, 40);
    mem[2]  = enc(T_JMP, 5);
    mem[3]  = enc(T_ST, 40);
    mem[4]  = enc(T_HLT, 0);
    mem[5]  = enc(T_OUT, 7);
    mem[6]  = enc(T_JMP, 4);
    mem[40] = 32'hDEAD_BEEF;
    in_q[0] = 32'h1234_5678;
    exp_in_dev = 3;
    run(cyc);
    chk(out_cnt == 1 && out_val == 32'h1234_5678, "R12 acc kept over no-op", out_val, 32'h1234_5678);
    chk(out_dev == 25'd7, "R10 device number", {7'd0, out_dev}, 32'd7);
    chk(mem[40] == 32'hDEAD_BEEF, "R9 R12 no write", mem[40], 32'hDEAD_BEEF);
    chk(flags == 5'd0, "R7 R12 flags unchanged", {27'd0, flags}, 32'd0);
    chk(cyc == 19, "R9 R12 cycle count", cyc, 19);
    chk(halted && halt_strobes == 0, "R11 halt sticky", halt_strobes, 0);
    chk(!in_dev_bad && !multi_strobe, "R3 R13 strobes", {30'd0, in_dev_bad, multi_strobe}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_vec++;
    n_bad++;
    $display("FAIL R11 watchdog: act=running exp=halted");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule